// File: doc/BRIEF.md
# Interrupt Vector Translation Latch

This block takes interrupt request codes from a strobed input and turns each one into an interrupt vector for a processor. A small programmable table of code/vector pairs does the mapping. When the table is switched off, the low byte of the code is used as the vector. The block holds a single pending vector. It presents that vector to the processor until the processor accepts it.

While a vector waits, a second request can arrive that maps to a different vector. A programmable policy then decides what happens. The block can flag an error, replace the pending vector, or substitute a fixed vector. A request that maps to the vector already waiting is absorbed. A code the table cannot translate raises a sticky error flag.

All configuration goes through one write port. Table entries use addresses 0 to DEPTH-1. Three control registers and an error-clear strobe follow directly after them.

Top module: `irq_vec_xlate`

## Requirements
- R1: After reset nothing is pending: `irq_req`=0, `irq_vec`=0 and `err`=0. In the same state all table entries are cleared, the policy is error (0), the substitute vector is 0 and translation is off.
- R2: A request with `req_code`=0 changes neither the pending vector nor `err`.
- R3: With translation off (address DEPTH+2, data bit 0 = 0), the vector is `req_code[7:0]`. A nonzero code whose low byte is zero is ignored.
- R4: With translation on (address DEPTH+2, data bit 0 = 1), entries are searched from index 0 upward and the first entry with a matching code gives the vector. An entry whose code is 0 ends the search, so later entries are never matched. A code with no match sets `err` and leaves the pending vector unchanged.
- R5: A request that maps to the vector already pending is dropped without error.
- R6: A request that maps to a different vector while one is pending obeys the policy in data bits [1:0] of address DEPTH.
  - 0 (and 3) sets `err` and keeps the pending vector.
  - 1 replaces the pending vector with the new one.
  - 2 makes the pending vector the substitute vector written at address DEPTH+1 (data bits [7:0]).
- R7: A request captured at a clock edge shows `irq_req`=1 with its vector on `irq_vec` right after that edge. The vector stays there until `irq_ack` is sampled high. That edge clears it to 0.
- R8: When `irq_ack` and a request fall in the same cycle, the old vector is retired and the request is captured as a fresh vector, with no conflict check.
- R9: `err` stays set until a configuration write to address DEPTH+3. If an error and such a write fall in the same cycle, `err` ends up set.
- R10: A write to address i < DEPTH loads entry i with code `cfg_data[23:8]` and vector `cfg_data[7:0]`. A request in the same cycle still sees the old table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_code | input | 16 | Request code |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration address |
| cfg_data | input | 24 | Configuration write data |
| irq_ack | input | 1 | Processor accepts the presented vector |
| irq_req | output | 1 | A vector is pending |
| irq_vec | output | 8 | Pending vector (0 when idle) |
| err | output | 1 | Sticky error flag |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is processor acceptance and a new request. The bench drives `irq_ack` together with a request whose vector differs from the pending one, under the error policy. It then expects the new vector and no error after that edge, because the accepted vector no longer counts as pending.

The second pair is an error-causing conflict and the error-clear write. The bench issues both in one cycle and judges that `err` is set afterwards.

A random phase mixes accepts, requests, policy changes and clears, and compares every cycle against a behavioural model.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  typedef enum logic [1:0] {
    POL_ERROR   = 2'd0,
    POL_REPLACE = 2'd1,
    POL_SUBST   = 2'd2
  } conflict_pol_e;
endpackage

// File: rtl/irqx_cfg.sv
module irqx_cfg
  import irqx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  output conflict_pol_e     policy,
  output logic [VEC_W-1:0]  subst_vec,
  output logic              xlate_en,
  output logic              err_clr
);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] A_SUB  = ADDR_W'(DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(DEPTH + 2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(DEPTH + 3);

  always_ff @(posedge clk) begin
    if (rst) begin
      policy    <= POL_ERROR;
      subst_vec <= '0;
      xlate_en  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == A_POL)  policy    <= conflict_pol_e'(cfg_data[1:0]);
      if (cfg_addr == A_SUB)  subst_vec <= cfg_data[VEC_W-1:0];
      if (cfg_addr == A_CTRL) xlate_en  <= cfg_data[0];
    end
  end

  assign err_clr = cfg_we && (cfg_addr == A_CLR);

  assert_pol_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == A_POL) |=> (policy == conflict_pol_e'($past(cfg_data[1:0]))));
endmodule

// File: rtl/irqx_table.sv
module irqx_table #(
  parameter int DEPTH  = 8,
  parameter int CODE_W = 16,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = CODE_W + VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [CODE_W-1:0] look_code,
  output logic              look_hit,
  output logic [VEC_W-1:0]  look_vec
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CODE_W-1:0] ent_code [DEPTH];
  logic [VEC_W-1:0]  ent_vec  [DEPTH];
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_tbl;
  logic [DEPTH:0]    alive;
  logic [DEPTH-1:0]  match;

  assign wr_idx = cfg_addr[IDX_W-1:0];
  assign wr_tbl = cfg_we && (cfg_addr < ADDR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_code[i] <= '0;
        ent_vec[i]  <= '0;
      end
    end else if (wr_tbl) begin
      ent_code[wr_idx] <= cfg_data[DATA_W-1:VEC_W];
      ent_vec[wr_idx]  <= cfg_data[VEC_W-1:0];
    end
  end

  // An entry takes part only while no earlier entry ended the table.
  assign alive[0] = 1'b1;
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign alive[g+1] = alive[g] && (ent_code[g] != '0);
    assign match[g]   = alive[g+1] && (ent_code[g] == look_code);
  end

  always_comb begin
    look_hit = 1'b0;
    look_vec = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        look_hit = 1'b1;
        look_vec = ent_vec[i];
      end
    end
  end

  assert_tbl_write_R10: assert property (@(posedge clk) disable iff (rst)
    wr_tbl |=> (ent_code[$past(wr_idx)] == $past(cfg_data[DATA_W-1:VEC_W]) &&
                ent_vec[$past(wr_idx)]  == $past(cfg_data[VEC_W-1:0])));
endmodule

// File: rtl/irqx_pending.sv
module irqx_pending
  import irqx_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int VEC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              xlate_en,
  input  logic              look_hit,
  input  logic [VEC_W-1:0]  look_vec,
  input  conflict_pol_e     policy,
  input  logic [VEC_W-1:0]  subst_vec,
  input  logic              err_clr,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              err
);
  logic [VEC_W-1:0] pend_q, base, cand, nxt;
  logic             set_err, err_q;

  assign cand = xlate_en ? look_vec : req_code[VEC_W-1:0];

  always_comb begin
    base    = (irq_ack && pend_q != '0) ? '0 : pend_q;
    nxt     = base;
    set_err = 1'b0;
    if (req_valid && req_code != '0) begin
      if (xlate_en && !look_hit) begin
        set_err = 1'b1;
      end else if (cand != '0) begin
        if (base == '0) begin
          nxt = cand;
        end else if (cand != base) begin
          case (policy)
            POL_REPLACE: nxt = cand;
            POL_SUBST:   nxt = subst_vec;
            default:     set_err = 1'b1;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      irq_req <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pend_q  <= nxt;
      irq_req <= (nxt != '0);
      err_q   <= set_err || (err_q && !err_clr);
    end
  end

  assign irq_vec = pend_q;
  assign err     = err_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0 && !irq_ack && !req_valid) |=> (pend_q == $past(pend_q)));
  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q != '0 && irq_ack && !req_valid) |=> (pend_q == '0 && !irq_req));
  assert_req_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req == (irq_vec != '0));
  assert_zero_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_code == '0 && !irq_ack && !err_clr) |=> ($stable(pend_q) && $stable(err_q)));
  assert_same_vec_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_code != '0 && !irq_ack && !err_clr && pend_q != '0 && cand == pend_q &&
     (look_hit || !xlate_en)) |=> ($stable(pend_q) && $stable(err_q)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/irq_vec_xlate.sv
module irq_vec_xlate
  import irqx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CODE_W = 16,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 4,
  parameter int DATA_W = CODE_W + VEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              err
);
  conflict_pol_e    policy;
  logic [VEC_W-1:0] subst_vec, look_vec;
  logic             xlate_en, err_clr, look_hit;

  irqx_cfg #(.DEPTH(DEPTH), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .policy(policy), .subst_vec(subst_vec), .xlate_en(xlate_en), .err_clr(err_clr)
  );

  irqx_table #(.DEPTH(DEPTH), .CODE_W(CODE_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W),
               .DATA_W(DATA_W)) u_tbl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .look_code(req_code), .look_hit(look_hit), .look_vec(look_vec)
  );

  irqx_pending #(.CODE_W(CODE_W), .VEC_W(VEC_W)) u_pend (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .xlate_en(xlate_en), .look_hit(look_hit), .look_vec(look_vec),
    .policy(policy), .subst_vec(subst_vec), .err_clr(err_clr), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .err(err)
  );
endmodule

// File: tb/tb_irq_vec_xlate.sv
module tb_irq_vec_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_code = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [23:0] cfg_data = '0;
  logic        irq_ack = 1'b0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        err;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";

  irq_vec_xlate dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .err(err)
  );

  always #5 clk = ~clk;

  // Behavioural reference model
  logic [15:0] m_code [8];
  logic [7:0]  m_vecs [8];
  logic [7:0]  m_pend, m_sub;
  logic [1:0]  m_pol;
  logic        m_err, m_xen;

  always @(posedge clk) begin
    logic [7:0] base, nx, v;
    logic       se, hit;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin m_code[i] = '0; m_vecs[i] = '0; end
      m_pend = '0; m_sub = '0; m_pol = '0; m_err = 1'b0; m_xen = 1'b0;
    end else begin
      base = (irq_ack && m_pend != 0) ? 8'd0 : m_pend;
      nx = base; se = 1'b0; hit = 1'b0; v = '0;
      if (req_valid && req_code != 0) begin
        if (m_xen) begin
          for (int i = 0; i < 8; i++) begin
            if (m_code[i] == 0) break;
            if (m_code[i] == req_code) begin hit = 1'b1; v = m_vecs[i]; break; end
          end
        end else begin
          hit = 1'b1; v = req_code[7:0];
        end
        if (!hit) se = 1'b1;
        else if (v != 0) begin
          if (base == 0) nx = v;
          else if (v != base) begin
            if (m_pol == 2'd1) nx = v;
            else if (m_pol == 2'd2) nx = m_sub;
            else se = 1'b1;
          end
        end
      end
      m_err  = se || (m_err && !(cfg_we && cfg_addr == 4'd11));
      m_pend = nx;
      if (cfg_we) begin
        if (cfg_addr < 4'd8) begin
          m_code[cfg_addr[2:0]] = cfg_data[23:8];
          m_vecs[cfg_addr[2:0]] = cfg_data[7:0];
        end
        if (cfg_addr == 4'd8)  m_pol = cfg_data[1:0];
        if (cfg_addr == 4'd9)  m_sub = cfg_data[7:0];
        if (cfg_addr == 4'd10) m_xen = cfg_data[0];
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
    chk(cur_tag, "model irq_vec", {24'd0, irq_vec}, {24'd0, m_pend});
    chk(cur_tag, "model irq_req", {31'd0, irq_req}, {31'd0, (m_pend != 0)});
    chk(cur_tag, "model err", {31'd0, err}, {31'd0, m_err});
    req_valid = 1'b0; req_code = '0; cfg_we = 1'b0; irq_ack = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [23:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    tick();
  endtask

  task automatic rq(input logic [15:0] c, input logic ack);
    req_valid = 1'b1; req_code = c; irq_ack = ack;
    tick();
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    tick();
    chk("R1", "reset irq_req", {31'd0, irq_req}, 0);
    chk("R1", "reset irq_vec", {24'd0, irq_vec}, 0);
    chk("R1", "reset err", {31'd0, err}, 0);

    cur_tag = "R3"; rq(16'h0005, 1'b0);
    chk("R3", "passthrough vec", {24'd0, irq_vec}, 32'h05);
    chk("R7", "req same edge", {31'd0, irq_req}, 1);
    cur_tag = "R7"; tick(); tick(); tick();
    chk("R7", "held vec", {24'd0, irq_vec}, 32'h05);
    irq_ack = 1'b1; tick();
    chk("R7", "ack clears", {31'd0, irq_req}, 0);
    cur_tag = "R3"; rq(16'h0100, 1'b0);
    chk("R3", "zero low byte ignored", {31'd0, irq_req}, 0);
    cur_tag = "R2"; rq(16'h0000, 1'b0);
    chk("R2", "zero code ignored", {31'd0, irq_req}, 0);
    chk("R2", "zero code no err", {31'd0, err}, 0);

    cur_tag = "R10";
    wr(4'd0, {16'h0100, 8'h21});
    wr(4'd1, {16'h0200, 8'h22});
    wr(4'd2, 24'h0);
    wr(4'd3, {16'h0300, 8'h23});
    wr(4'd10, 24'h1);
    cur_tag = "R4"; rq(16'h0200, 1'b0);
    chk("R4", "table lookup", {24'd0, irq_vec}, 32'h22);
    rq(16'h0300, 1'b0);
    chk("R4", "past end marker err", {31'd0, err}, 1);
    chk("R4", "miss keeps pending", {24'd0, irq_vec}, 32'h22);
    cur_tag = "R9"; rq(16'h0000, 1'b0); tick();
    chk("R9", "err sticky", {31'd0, err}, 1);
    wr(4'd11, 24'h0);
    chk("R9", "err cleared", {31'd0, err}, 0);
    cur_tag = "R5"; rq(16'h0200, 1'b0);
    chk("R5", "same vec kept", {24'd0, irq_vec}, 32'h22);
    chk("R5", "same vec no err", {31'd0, err}, 0);
    cur_tag = "R6"; rq(16'h0100, 1'b0);
    chk("R6", "error policy err", {31'd0, err}, 1);
    chk("R6", "error policy keeps", {24'd0, irq_vec}, 32'h22);
    wr(4'd11, 24'h0);
    wr(4'd8, 24'h1);
    rq(16'h0100, 1'b0);
    chk("R6", "replace policy", {24'd0, irq_vec}, 32'h21);
    wr(4'd9, 24'h3F);
    wr(4'd8, 24'h2);
    rq(16'h0200, 1'b0);
    chk("R6", "substitute policy", {24'd0, irq_vec}, 32'h3F);
    chk("R6", "substitute no err", {31'd0, err}, 0);
    wr(4'd8, 24'h0);
    cur_tag = "R8"; rq(16'h0100, 1'b1);
    chk("R8", "ack+req fresh vec", {24'd0, irq_vec}, 32'h21);
    chk("R8", "ack+req no err", {31'd0, err}, 0);
    cur_tag = "R9";
    cfg_we = 1'b1; cfg_addr = 4'd11; cfg_data = '0;
    rq(16'h0200, 1'b0);
    chk("R9", "set wins over clear", {31'd0, err}, 1);
    wr(4'd11, 24'h0);

    cur_tag = "R6";
    for (int n = 0; n < 400; n++) begin
      logic [15:0] codes [7];
      int r;
      codes = '{16'h0, 16'h0100, 16'h0200, 16'h0300, 16'h0400, 16'h0005, 16'h0105};
      r = $urandom_range(0, 9);
      if (r == 0) begin cfg_we = 1'b1; cfg_addr = 4'd8; cfg_data = 24'($urandom_range(0, 3)); end
      else if (r == 1) begin cfg_we = 1'b1; cfg_addr = 4'd11; cfg_data = '0; end
      else if (r == 2) begin cfg_we = 1'b1; cfg_addr = 4'd10; cfg_data = 24'($urandom_range(0, 1)); end
      else if (r == 3) begin cfg_we = 1'b1; cfg_addr = 4'd9; cfg_data = 24'($urandom_range(0, 255)); end
      req_valid = ($urandom_range(0, 1) == 1);
      req_code  = codes[$urandom_range(0, 6)];
      irq_ack   = ($urandom_range(0, 2) == 0);
      tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule